// File: doc/BRIEF.md
# Sticky Status Flag Bank With Read-Clear

This block gathers the event and pin conditions of a position-counter device into three byte-wide status registers that a host reads over a simple register port. Event conditions are held in sticky flags. Each flag sets on a one-cycle event strobe or on an asserted condition, and stays set until the host reads an address that belongs to that flag's clearing set. Some clearing sets include data registers that live outside this block. Next to the sticky flags there is a live mirror of the touch-probe pin and a filtered copy of the interface-select strap pin.

The host issues a read by raising `rdEn` for one cycle with an address on `rdAddr`. One cycle later `rdData` shows the byte as it was before any clear caused by that read. `rdData` keeps that value until the next read. If an event and a clearing read arrive in the same cycle, the event wins, so no event is lost. All inputs are taken to be synchronous to `clk`.

Top module: `statusFlagBank`

## Requirements
- R1: After asynchronous reset (`rstN` low), all sticky flags, the filtered strap and `rdData` are 0.
- R2: The reference-overflow flag is bit 1 of address 0x48. It is set by `refOvfEvt` and cleared by a read of 0x48.
- R3: The probe-valid flag is bit 0 of address 0x48. It is set by `tpLoadEvt` and cleared by a read of 0x48, 0x0C or 0x0E.
- R4: The external-error flag is bit 3 of both 0x49 and 0x4A. It is set while `extErrPinN` is low, or while `intErr` is high with `intErrMask` low. A masked internal error does not set it. A read of 0x49 or 0x4A clears it.
- R5: The external-warning flag is bit 2 of both 0x49 and 0x4A. It is set while `extWarnPinN` is low, or while `intWarn` is high with `intWarnMask` low. A read of 0x49 or 0x4A clears it.
- R6: The collision flag is bit 1 of both 0x49 and 0x4A. It is set by `collisionEvt` and cleared by a read of 0x49 or 0x4A.
- R7: Bit 0 of 0x49 returns the level of `tpPin` in the read cycle. It is not sticky.
- R8: Bit 0 of 0x4A returns the filtered strap. The filtered strap takes the value of `ifSelPin` only after `ifSelPin` has differed from it for FILT_CYCLES consecutive clocks. A shorter excursion has no effect.
- R9: A set condition in the same cycle as a clearing read leaves the flag set. That read returns the value the flag had before the cycle.
- R10: `rdData` is loaded one cycle after a read and then holds until the next read. Bits 7:4 of 0x49 and 0x4A and bits 7:2 of 0x48 read 0. Any other address, including 0x0C and 0x0E, reads 0x00.
- R11: A read of 0x48 leaves the flags of 0x49/0x4A unchanged. A read of 0x49 or 0x4A leaves the flags of 0x48 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refOvfEvt | input | 1 | Reference counter went below the lower limit (one-cycle strobe) |
| tpLoadEvt | input | 1 | Touch-probe registers were loaded (one-cycle strobe) |
| collisionEvt | input | 1 | Internal bus access collision (one-cycle strobe) |
| extErrPinN | input | 1 | External error pin, active low |
| extWarnPinN | input | 1 | External warning pin, active low |
| intErr | input | 1 | Internal error condition |
| intErrMask | input | 1 | Masks `intErr` when high |
| intWarn | input | 1 | Internal warning condition |
| intWarnMask | input | 1 | Masks `intWarn` when high |
| tpPin | input | 1 | Touch-probe input pin level |
| ifSelPin | input | 1 | Interface-select strap, 1 = open (simple serial mode) |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, valid the cycle after `rdEn` |

## Verification
A flag stuck at 1, or one that is not cleared by a member of its clearing set, shows up as a wrong bit at the next read of any address that maps the flag. That read comes two cycles after the fault at the earliest. A lost event, or a clear that beats a same-cycle set, shows only at the second read after the event, so the bench reads the same address twice in a row. A filter counter that is off by one moves the strap edge by one clock. The reference model compares the strap read on every cycle, so such an error appears as soon as the host reads 0x4A near the edge.

// File: rtl/statusFlagPkg.sv
package statusFlagPkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PROBE = 2'd1,
    SEL_PINS  = 2'd2,
    SEL_STRAP = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   capture;
    rdSel_e sel;
    logic   clrOvf;
    logic   clrTpv;
    logic   clrExt;
  } ctrlStrobes_t;

  localparam int IDX_TPV    = 0;
  localparam int IDX_OVF    = 1;
  localparam int IDX_COL    = 2;
  localparam int IDX_WARN   = 3;
  localparam int IDX_ERR    = 4;
  localparam int NUM_STICKY = 5;

endpackage

// File: rtl/stickyFlag.sv
module stickyFlag (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic clrIn,
  output logic flagOut
);
  // set has priority over clear so a coincident event is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagOut <= 1'b0;
    else       flagOut <= setIn | (flagOut & ~clrIn);
  end
endmodule

// File: rtl/strapFilter.sv
module strapFilter #(
  parameter int   FILT_CYCLES = 16,
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CNT_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut <= RESET_LEVEL;
      runCnt  <= '0;
    end else if (rawIn == filtOut) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      filtOut <= rawIn;
      runCnt  <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/statusCtrl.sv
module statusCtrl
  import statusFlagPkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] ADDR_PROBE = 'h48,
  parameter logic [ADDR_W-1:0] ADDR_PINS  = 'h49,
  parameter logic [ADDR_W-1:0] ADDR_STRAP = 'h4A,
  parameter logic [ADDR_W-1:0] ADDR_TPA   = 'h0C,
  parameter logic [ADDR_W-1:0] ADDR_TPB   = 'h0E
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes         = '0;
    strobes.sel     = SEL_NONE;
    strobes.capture = rdEn;
    if (rdEn) begin
      if (rdAddr == ADDR_PROBE) begin
        strobes.sel    = SEL_PROBE;
        strobes.clrOvf = 1'b1;
        strobes.clrTpv = 1'b1;
      end else if (rdAddr == ADDR_PINS) begin
        strobes.sel    = SEL_PINS;
        strobes.clrExt = 1'b1;
      end else if (rdAddr == ADDR_STRAP) begin
        strobes.sel    = SEL_STRAP;
        strobes.clrExt = 1'b1;
      end else if (rdAddr == ADDR_TPA || rdAddr == ADDR_TPB) begin
        strobes.clrTpv = 1'b1;
      end
    end
  end
endmodule

// File: rtl/statusDatapath.sv
module statusDatapath
  import statusFlagPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              refOvfEvt,
  input  logic              tpLoadEvt,
  input  logic              collisionEvt,
  input  logic              errCond,
  input  logic              warnCond,
  input  logic              tpPin,
  input  logic              strapLevel,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_STICKY-1:0] setVec;
  logic [NUM_STICKY-1:0] clrVec;
  logic [NUM_STICKY-1:0] flagVec;
  logic [DATA_W-1:0]     byteNext;

  always_comb begin
    setVec           = '0;
    setVec[IDX_TPV]  = tpLoadEvt;
    setVec[IDX_OVF]  = refOvfEvt;
    setVec[IDX_COL]  = collisionEvt;
    setVec[IDX_WARN] = warnCond;
    setVec[IDX_ERR]  = errCond;
    clrVec           = '0;
    clrVec[IDX_TPV]  = strobes.clrTpv;
    clrVec[IDX_OVF]  = strobes.clrOvf;
    clrVec[IDX_COL]  = strobes.clrExt;
    clrVec[IDX_WARN] = strobes.clrExt;
    clrVec[IDX_ERR]  = strobes.clrExt;
  end

  for (genvar i = 0; i < NUM_STICKY; i++) begin : gSticky
    stickyFlag flag_i (
      .clk    (clk),
      .rstN   (rstN),
      .setIn  (setVec[i]),
      .clrIn  (clrVec[i]),
      .flagOut(flagVec[i])
    );
  end

  always_comb begin
    byteNext = '0;
    unique case (strobes.sel)
      SEL_PROBE: begin
        byteNext[0] = flagVec[IDX_TPV];
        byteNext[1] = flagVec[IDX_OVF];
      end
      SEL_PINS, SEL_STRAP: begin
        byteNext[0] = (strobes.sel == SEL_PINS) ? tpPin : strapLevel;
        byteNext[1] = flagVec[IDX_COL];
        byteNext[2] = flagVec[IDX_WARN];
        byteNext[3] = flagVec[IDX_ERR];
      end
      default: byteNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobes.capture) rdData <= byteNext;
  end
endmodule

// File: rtl/statusFlagBank.sv
module statusFlagBank
  import statusFlagPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int FILT_CYCLES = 16,
  parameter logic [ADDR_W-1:0] ADDR_PROBE = 'h48,
  parameter logic [ADDR_W-1:0] ADDR_PINS  = 'h49,
  parameter logic [ADDR_W-1:0] ADDR_STRAP = 'h4A,
  parameter logic [ADDR_W-1:0] ADDR_TPA   = 'h0C,
  parameter logic [ADDR_W-1:0] ADDR_TPB   = 'h0E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refOvfEvt,
  input  logic              tpLoadEvt,
  input  logic              collisionEvt,
  input  logic              extErrPinN,
  input  logic              extWarnPinN,
  input  logic              intErr,
  input  logic              intErrMask,
  input  logic              intWarn,
  input  logic              intWarnMask,
  input  logic              tpPin,
  input  logic              ifSelPin,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobes_t strobes;
  logic strapLevel;
  logic errCond;
  logic warnCond;

  assign errCond  = ~extErrPinN  | (intErr  & ~intErrMask);
  assign warnCond = ~extWarnPinN | (intWarn & ~intWarnMask);

  statusCtrl #(
    .ADDR_W(ADDR_W), .ADDR_PROBE(ADDR_PROBE), .ADDR_PINS(ADDR_PINS),
    .ADDR_STRAP(ADDR_STRAP), .ADDR_TPA(ADDR_TPA), .ADDR_TPB(ADDR_TPB)
  ) ctrl_i (
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .strobes(strobes)
  );

  strapFilter #(.FILT_CYCLES(FILT_CYCLES), .RESET_LEVEL(1'b0)) filt_i (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (ifSelPin),
    .filtOut(strapLevel)
  );

  statusDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .refOvfEvt   (refOvfEvt),
    .tpLoadEvt   (tpLoadEvt),
    .collisionEvt(collisionEvt),
    .errCond     (errCond),
    .warnCond    (warnCond),
    .tpPin       (tpPin),
    .strapLevel  (strapLevel),
    .rdData      (rdData)
  );
endmodule

// File: rtl/statusFlagBank_chk.sv
module statusFlagBank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_PROBE = 'h48,
  parameter logic [ADDR_W-1:0] ADDR_PINS  = 'h49,
  parameter logic [ADDR_W-1:0] ADDR_STRAP = 'h4A
) (
  input logic              clk,
  input logic              rstN,
  input logic              refOvfEvt,
  input logic              tpLoadEvt,
  input logic              collisionEvt,
  input logic              extErrPinN,
  input logic              tpPin,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  logic rdProbe, rdPins, rdStrap, rdOther;
  assign rdProbe = rdEn && rdAddr == ADDR_PROBE;
  assign rdPins  = rdEn && rdAddr == ADDR_PINS;
  assign rdStrap = rdEn && rdAddr == ADDR_STRAP;
  assign rdOther = rdEn && !rdProbe && !rdPins && !rdStrap;

  assert_probe_unused_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdProbe |=> rdData[DATA_W-1:2] == '0);

  assert_other_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdOther |=> rdData == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_ovf_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdProbe && $past(refOvfEvt)) |=> rdData[1]);

  assert_tpv_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdProbe && $past(tpLoadEvt)) |=> rdData[0]);

  assert_ovf_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdProbe && $past(rdProbe) && !$past(refOvfEvt)) |=> !rdData[1]);

  assert_err_pin_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdPins && !$past(extErrPinN)) |=> rdData[3]);

  assert_collision_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((rdPins || rdStrap) && $past(collisionEvt)) |=> rdData[1]);

  assert_live_probe_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdPins |=> rdData[0] == $past(tpPin));
endmodule

bind statusFlagBank statusFlagBank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_PROBE(ADDR_PROBE),
  .ADDR_PINS(ADDR_PINS), .ADDR_STRAP(ADDR_STRAP)
) chk_i (
  .clk(clk), .rstN(rstN), .refOvfEvt(refOvfEvt), .tpLoadEvt(tpLoadEvt),
  .collisionEvt(collisionEvt), .extErrPinN(extErrPinN), .tpPin(tpPin),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/statusFlagBank_tb_top.sv
module statusFlagBank_tb_top;
  localparam int FILT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refOvfEvt = 0, tpLoadEvt = 0, collisionEvt = 0;
  logic extErrPinN = 1, extWarnPinN = 1;
  logic intErr = 0, intErrMask = 0, intWarn = 0, intWarnMask = 0;
  logic tpPin = 0, ifSelPin = 0, rdEn = 0;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] rdData;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  statusFlagBank #(.FILT_CYCLES(FILT)) dut_i (
    .clk(clk), .rstN(rstN), .refOvfEvt(refOvfEvt), .tpLoadEvt(tpLoadEvt),
    .collisionEvt(collisionEvt), .extErrPinN(extErrPinN), .extWarnPinN(extWarnPinN),
    .intErr(intErr), .intErrMask(intErrMask), .intWarn(intWarn),
    .intWarnMask(intWarnMask), .tpPin(tpPin), .ifSelPin(ifSelPin),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit mOvf, mTpv, mErr, mWarn, mCol, mFilt;
  int mRun;
  logic [7:0] mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOvf = 0; mTpv = 0; mErr = 0; mWarn = 0; mCol = 0; mFilt = 0; mRun = 0; mRd = 8'h00;
    end else begin
      if (rdEn) begin
        case (rdAddr)
          8'h48:   mRd = {6'b0, mOvf, mTpv};
          8'h49:   mRd = {4'b0, mErr, mWarn, mCol, tpPin};
          8'h4A:   mRd = {4'b0, mErr, mWarn, mCol, mFilt};
          default: mRd = 8'h00;
        endcase
        if (rdAddr == 8'h48) begin mOvf = 0; mTpv = 0; end
        if (rdAddr == 8'h0C || rdAddr == 8'h0E) mTpv = 0;
        if (rdAddr == 8'h49 || rdAddr == 8'h4A) begin mErr = 0; mWarn = 0; mCol = 0; end
      end
      if (refOvfEvt) mOvf = 1;
      if (tpLoadEvt) mTpv = 1;
      if (collisionEvt) mCol = 1;
      if (!extErrPinN || (intErr && !intErrMask)) mErr = 1;
      if (!extWarnPinN || (intWarn && !intWarnMask)) mWarn = 1;
      if (ifSelPin == mFilt) mRun = 0;
      else if (mRun + 1 >= FILT) begin mFilt = ifSelPin; mRun = 0; end
      else mRun = mRun + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) check("R10 per-cycle model", rdData, mRd);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readReg(input logic [7:0] a);
    @(negedge clk); rdEn = 1; rdAddr = a;
    @(negedge clk); rdEn = 0; rdAddr = 8'h00;
  endtask

  // 0 ovf, 1 tp load, 2 collision, 3 err pin, 4 warn pin
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: refOvfEvt = 1;
      1: tpLoadEvt = 1;
      2: collisionEvt = 1;
      3: extErrPinN = 0;
      default: extWarnPinN = 0;
    endcase
    @(negedge clk);
    refOvfEvt = 0; tpLoadEvt = 0; collisionEvt = 0; extErrPinN = 1; extWarnPinN = 1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 reset rdData", rdData, 8'h00);
    rstN = 1;
    readReg(8'h48); check("R1 probe byte after reset", rdData, 8'h00);
    readReg(8'h4A); check("R1 strap byte after reset", rdData, 8'h00);

    pulse(0);
    readReg(8'h48); check("R2 ovf set", rdData, 8'h02);
    readReg(8'h48); check("R2 ovf cleared", rdData, 8'h00);

    pulse(1);
    readReg(8'h0C); check("R10 tp data addr reads zero", rdData, 8'h00);
    readReg(8'h48); check("R3 cleared by 0x0C", rdData, 8'h00);
    pulse(1);
    readReg(8'h0E);
    readReg(8'h48); check("R3 cleared by 0x0E", rdData, 8'h00);
    pulse(1);
    readReg(8'h48); check("R3 tpv set", rdData, 8'h01);
    readReg(8'h48); check("R3 tpv cleared by 0x48", rdData, 8'h00);

    pulse(3);
    readReg(8'h4A); check("R4 err via pin at 0x4A", rdData, 8'h08);
    readReg(8'h49); check("R4 err cleared by 0x4A", rdData, 8'h00);
    @(negedge clk); intErr = 1; intErrMask = 1;
    @(negedge clk); intErr = 0; intErrMask = 0;
    readReg(8'h49); check("R4 masked internal error ignored", rdData, 8'h00);
    @(negedge clk); intErr = 1;
    @(negedge clk); intErr = 0;
    readReg(8'h49); check("R4 unmasked internal error", rdData, 8'h08);

    pulse(4);
    readReg(8'h49); check("R5 warn via pin", rdData, 8'h04);
    @(negedge clk); intWarn = 1;
    @(negedge clk); intWarn = 0;
    readReg(8'h4A); check("R5 warn internal at 0x4A", rdData, 8'h04);
    readReg(8'h49); check("R5 warn cleared", rdData, 8'h00);

    pulse(2);
    readReg(8'h4A); check("R6 collision set", rdData, 8'h02);
    readReg(8'h49); check("R6 collision cleared", rdData, 8'h00);

    tpPin = 1;
    readReg(8'h49); check("R7 probe pin high", rdData, 8'h01);
    tpPin = 0;
    readReg(8'h49); check("R7 probe pin low", rdData, 8'h00);

    pulse(0); pulse(2);
    readReg(8'h48); check("R11 ovf read", rdData, 8'h02);
    readReg(8'h49); check("R11 collision kept after 0x48 read", rdData, 8'h02);
    pulse(1);
    readReg(8'h4A);
    readReg(8'h48); check("R11 tpv kept after 0x4A read", rdData, 8'h01);

    @(negedge clk); refOvfEvt = 1; rdEn = 1; rdAddr = 8'h48;
    @(negedge clk); refOvfEvt = 0; rdEn = 0; rdAddr = 8'h00;
    check("R9 read returns pre-clear value", rdData, 8'h00);
    idle(3);
    check("R10 rdData holds without read", rdData, 8'h00);
    readReg(8'h48); check("R9 flag kept after coincident clear", rdData, 8'h02);
    readReg(8'h57); check("R10 unmapped address", rdData, 8'h00);

    @(negedge clk); ifSelPin = 1;
    idle(FILT / 2);
    @(negedge clk); ifSelPin = 0;
    idle(FILT + 4);
    readReg(8'h4A); check("R8 short excursion ignored", rdData, 8'h00);
    @(negedge clk); ifSelPin = 1;
    idle(FILT / 2);
    readReg(8'h4A); check("R8 strap not yet changed", rdData, 8'h00);
    idle(FILT);
    readReg(8'h4A); check("R8 strap changed after filter", rdData, 8'h01);
    for (int k = 0; k < FILT + 2; k++) readReg(8'h4A);
    check("R8 strap stays high", rdData, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule